// File: doc/BRIEF.md
# Level-Based Interrupt Pre-emption Controller

This block decides whether a pending interrupt may take the processor away from the code that is running. It keeps the level the processor is executing at, a threshold that software writes, and a global enable bit. Every source presents a pending flag and an 8-bit level. Each cycle the block works out the highest-level request that qualifies. If the global enable is set and no offer is outstanding, it offers that request to the core through a valid/acknowledge pair.

When the core acknowledges, the block enters the trap. It records the interrupted program counter, saves the previous level and the previous enable bit, raises the running level to the level of the taken request, and clears the global enable. A handler that sets the enable again can itself be pre-empted, but only by a strictly higher level, which gives nested handlers. A trap-return pulse restores the saved level and enable bit, and emits a one-cycle resume pulse that carries the saved program counter.

Top module: `lvl_preempt_ctrl`

## Requirements
- R1: After a synchronous reset the running level, threshold, global enable, saved level, saved enable, saved PC, offer valid and resume pulse are all 0.
- R2: While the global enable is 0, no offer is raised, whatever the level of the pending requests.
- R3: A pending request whose level is 0 is never offered.
- R4: A request qualifies only if its level is strictly greater than both the threshold and the running level. A request whose level equals either value is ignored.
- R5: Among the qualifying requests, the one with the highest level wins. On equal levels the higher source index wins.
- R6: An offer is raised on the clock edge after the one where its conditions hold. Until it is acknowledged, the offer holds its ID and level stable, even if the requests change.
- R7: On an acknowledged offer the running level becomes the offered level. The old running level goes to the saved level, the old enable goes to the saved enable, and the core PC goes to the saved PC. The global enable and the offer valid both clear.
- R8: Inside a handler with the enable set again, only a strictly higher level pre-empts. On pre-emption the saved PC captures the PC of the handler.
- R9: A trap-return pulse restores the running level from the saved level and the enable from the saved enable. On the next cycle it gives a one-cycle resume pulse whose PC is the saved PC.
- R10: A threshold write takes effect on the next clock edge and is visible on the threshold output.
- R11: When a software write to the enable meets an acknowledge or a trap return in the same cycle, the software write is dropped. The enable then takes the value set by trap entry or by the restore.
- R12: When an acknowledge and a trap-return pulse meet in the same cycle, trap entry is performed and the return is ignored. No resume pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value for the global enable |
| thresh_wr | input | 1 | Software write strobe for the threshold |
| thresh_wdata | input | LVL_W | Threshold value |
| req_pend | input | NUM_SRC | Pending flag per source |
| req_lvl | input | NUM_SRC*LVL_W | Level per source; source i in bits [i*LVL_W +: LVL_W] |
| core_pc | input | PC_W | PC of the current context, captured on trap entry |
| trap_valid | output | 1 | Offer of a trap to the core |
| trap_id | output | clog2(NUM_SRC) | Source index of the offer |
| trap_lvl | output | LVL_W | Level of the offer |
| trap_ack | input | 1 | Core accepts the offer |
| mret | input | 1 | Trap-return pulse |
| resume_valid | output | 1 | One-cycle pulse after a trap return |
| resume_pc | output | PC_W | PC to resume at |
| cur_lvl | output | LVL_W | Running execution level |
| thresh | output | LVL_W | Threshold |
| gie | output | 1 | Global interrupt enable |
| prev_lvl | output | LVL_W | Level saved at trap entry |
| prev_gie | output | 1 | Enable saved at trap entry |
| epc | output | PC_W | PC saved at trap entry |

## Verification
Trap entry, trap return and the software write to the enable all update the same enable and level registers, so they can land on one clock edge. The bench drives an acknowledge together with an enable write of 1 and expects the enable to end at 0. It drives a trap return together with an enable write of 0 and expects the restored value. It also drives an acknowledge together with a trap return and expects the taken level with no resume pulse.

// File: rtl/lvl_preempt_pkg.sv
package lvl_preempt_pkg;
  parameter int unsigned LVL_W = 8;
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lvl_preempt_arb.sv
module lvl_preempt_arb
  import lvl_preempt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       req_pend,
  input  logic [NUM_SRC*LVL_W-1:0] req_lvl,
  input  lvl_t                     thresh,
  input  lvl_t                     cur_lvl,
  output logic                     any_q,
  output logic [ID_W-1:0]          win_id,
  output lvl_t                     win_lvl
);
  lvl_t               eff_thr;
  logic [NUM_SRC-1:0] qual;
  lvl_t               src_lvl [NUM_SRC];

  assign eff_thr = lvl_max(thresh, cur_lvl);

  // a level of 0 can never exceed eff_thr, so it is never qualified
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_lvl[g] = req_lvl[g*LVL_W +: LVL_W];
    assign qual[g]    = req_pend[g] && (src_lvl[g] > eff_thr);
  end

  // ascending scan with >= lets the higher index win on equal levels
  always_comb begin
    any_q   = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!any_q || src_lvl[i] >= win_lvl)) begin
        any_q   = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/lvl_preempt_offer.sv
module lvl_preempt_offer
  import lvl_preempt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gie,
  input  logic            mret,
  input  logic            any_q,
  input  logic [ID_W-1:0] win_id,
  input  lvl_t            win_lvl,
  input  logic            trap_ack,
  output logic            trap_valid,
  output logic [ID_W-1:0] trap_id,
  output lvl_t            trap_lvl,
  output logic            take
);
  assign take = trap_valid && trap_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_id    <= '0;
      trap_lvl   <= '0;
    end else if (take) begin
      trap_valid <= 1'b0;
    end else if (!trap_valid && gie && any_q && !mret) begin
      trap_valid <= 1'b1;
      trap_id    <= win_id;
      trap_lvl   <= win_lvl;
    end
  end
endmodule

// File: rtl/lvl_preempt_ctx.sv
module lvl_preempt_ctx
  import lvl_preempt_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  lvl_t            take_lvl,
  input  logic [PC_W-1:0] core_pc,
  input  logic            mret,
  input  logic            gie_wr,
  input  logic            gie_wdata,
  input  logic            thresh_wr,
  input  lvl_t            thresh_wdata,
  output lvl_t            cur_lvl,
  output lvl_t            thresh,
  output logic            gie,
  output lvl_t            prev_lvl,
  output logic            prev_gie,
  output logic [PC_W-1:0] epc,
  output logic            resume_valid,
  output logic [PC_W-1:0] resume_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl      <= '0;
      thresh       <= '0;
      gie          <= 1'b0;
      prev_lvl     <= '0;
      prev_gie     <= 1'b0;
      epc          <= '0;
      resume_valid <= 1'b0;
      resume_pc    <= '0;
    end else begin
      resume_valid <= 1'b0;
      if (thresh_wr) thresh <= thresh_wdata;
      // entry beats return, return beats a software enable write
      if (take) begin
        prev_lvl <= cur_lvl;
        prev_gie <= gie;
        cur_lvl  <= take_lvl;
        gie      <= 1'b0;
        epc      <= core_pc;
      end else if (mret) begin
        cur_lvl      <= prev_lvl;
        gie          <= prev_gie;
        resume_valid <= 1'b1;
        resume_pc    <= epc;
      end else if (gie_wr) begin
        gie <= gie_wdata;
      end
    end
  end
endmodule

// File: rtl/lvl_preempt_ctrl.sv
module lvl_preempt_ctrl
  import lvl_preempt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PC_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         gie_wr,
  input  logic                         gie_wdata,
  input  logic                         thresh_wr,
  input  logic [LVL_W-1:0]             thresh_wdata,
  input  logic [NUM_SRC-1:0]           req_pend,
  input  logic [NUM_SRC*LVL_W-1:0]     req_lvl,
  input  logic [PC_W-1:0]              core_pc,
  output logic                         trap_valid,
  output logic [$clog2(NUM_SRC)-1:0]   trap_id,
  output logic [LVL_W-1:0]             trap_lvl,
  input  logic                         trap_ack,
  input  logic                         mret,
  output logic                         resume_valid,
  output logic [PC_W-1:0]              resume_pc,
  output logic [LVL_W-1:0]             cur_lvl,
  output logic [LVL_W-1:0]             thresh,
  output logic                         gie,
  output logic [LVL_W-1:0]             prev_lvl,
  output logic                         prev_gie,
  output logic [PC_W-1:0]              epc
);
  localparam int ID_W = $clog2(NUM_SRC);

  logic            any_q;
  logic [ID_W-1:0] win_id;
  lvl_t            win_lvl;
  logic            take;

  lvl_preempt_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_pend (req_pend),
    .req_lvl  (req_lvl),
    .thresh   (thresh),
    .cur_lvl  (cur_lvl),
    .any_q    (any_q),
    .win_id   (win_id),
    .win_lvl  (win_lvl)
  );

  lvl_preempt_offer #(.NUM_SRC(NUM_SRC)) u_offer (
    .clk        (clk),
    .rst        (rst),
    .gie        (gie),
    .mret       (mret),
    .any_q      (any_q),
    .win_id     (win_id),
    .win_lvl    (win_lvl),
    .trap_ack   (trap_ack),
    .trap_valid (trap_valid),
    .trap_id    (trap_id),
    .trap_lvl   (trap_lvl),
    .take       (take)
  );

  lvl_preempt_ctx #(.PC_W(PC_W)) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .take_lvl     (trap_lvl),
    .core_pc      (core_pc),
    .mret         (mret),
    .gie_wr       (gie_wr),
    .gie_wdata    (gie_wdata),
    .thresh_wr    (thresh_wr),
    .thresh_wdata (thresh_wdata),
    .cur_lvl      (cur_lvl),
    .thresh       (thresh),
    .gie          (gie),
    .prev_lvl     (prev_lvl),
    .prev_gie     (prev_gie),
    .epc          (epc),
    .resume_valid (resume_valid),
    .resume_pc    (resume_pc)
  );
endmodule

// File: rtl/lvl_preempt_ctrl_chk.sv
module lvl_preempt_ctrl_chk
  import lvl_preempt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PC_W    = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       gie_wr,
  input logic                       gie_wdata,
  input logic                       thresh_wr,
  input logic [LVL_W-1:0]           thresh_wdata,
  input logic [NUM_SRC-1:0]         req_pend,
  input logic [NUM_SRC*LVL_W-1:0]   req_lvl,
  input logic [PC_W-1:0]            core_pc,
  input logic                       trap_valid,
  input logic [$clog2(NUM_SRC)-1:0] trap_id,
  input logic [LVL_W-1:0]           trap_lvl,
  input logic                       trap_ack,
  input logic                       mret,
  input logic                       resume_valid,
  input logic [PC_W-1:0]            resume_pc,
  input logic [LVL_W-1:0]           cur_lvl,
  input logic [LVL_W-1:0]           thresh,
  input logic                       gie,
  input logic [LVL_W-1:0]           prev_lvl,
  input logic                       prev_gie,
  input logic [PC_W-1:0]            epc
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trap_valid && !gie && cur_lvl == '0 && thresh == '0 && !resume_valid));

  // R2
  offer_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_valid) |-> $past(gie));

  // R3
  no_zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> trap_lvl != '0);

  // R4
  above_threshold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_valid) |-> (trap_lvl > $past(thresh)) && (trap_lvl > $past(cur_lvl)));

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !trap_ack) |=> (trap_valid && $stable(trap_id) && $stable(trap_lvl)));

  // R7
  entry_update_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_ack) |=>
      (!gie && !trap_valid && cur_lvl == $past(trap_lvl) && epc == $past(core_pc)
       && prev_lvl == $past(cur_lvl)));

  // R9
  return_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (mret && !(trap_valid && trap_ack)) |=>
      (resume_valid && resume_pc == $past(epc) && cur_lvl == $past(prev_lvl)
       && gie == $past(prev_gie)));

  // R12
  entry_beats_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mret && trap_valid && trap_ack) |=> !resume_valid);
endmodule

bind lvl_preempt_ctrl lvl_preempt_ctrl_chk #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_chk (.*);

// File: tb/lvl_preempt_ctrl_tb.sv
module lvl_preempt_ctrl_tb;
  localparam int NS = 8;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gie_wr = 1'b0, gie_wdata = 1'b0, thresh_wr = 1'b0;
  logic [7:0]    thresh_wdata = '0;
  logic [NS-1:0] req_pend = '0;
  logic [NS*8-1:0] req_lvl = '0;
  logic [PW-1:0] core_pc = '0;
  logic          trap_ack = 1'b0, mret = 1'b0;
  logic          trap_valid, resume_valid, gie, prev_gie;
  logic [2:0]    trap_id;
  logic [7:0]    trap_lvl, cur_lvl, thresh, prev_lvl;
  logic [PW-1:0] resume_pc, epc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvl_preempt_ctrl #(.NUM_SRC(NS), .PC_W(PW)) u_dut (.*);

  typedef struct packed {
    logic [7:0]  pend;
    logic [63:0] lvl;
    logic [7:0]  thr;
    logic        ev;
    logic [2:0]  eid;
    logic [7:0]  elvl;
  } vec_t;

  // levels packed with source 0 in the low byte
  localparam vec_t VEC [7] = '{
    '{8'h01, 64'h0000_0000_0000_0005, 8'h00, 1'b1, 3'd0, 8'h05}, // R4 above threshold
    '{8'h01, 64'h0000_0000_0000_0005, 8'h05, 1'b0, 3'd0, 8'h00}, // R4 equal to threshold
    '{8'h01, 64'h0000_0000_0000_0000, 8'h00, 1'b0, 3'd0, 8'h00}, // R3 level zero
    '{8'h06, 64'h0000_0000_0009_0300, 8'h02, 1'b1, 3'd2, 8'h09}, // R5 highest level
    '{8'h4A, 64'h0007_0000_0700_0700, 8'h00, 1'b1, 3'd6, 8'h07}, // R5 tie, higher index
    '{8'h81, 64'hFF00_0000_0000_00FE, 8'hFE, 1'b1, 3'd7, 8'hFF}, // R4 top of range
    '{8'h30, 64'h0000_0304_0000_0000, 8'h04, 1'b0, 3'd0, 8'h00}  // R4 none above
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; gie_wr = 0; thresh_wr = 0; trap_ack = 0; mret = 0;
    req_pend = '0; req_lvl = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic set_thresh(input logic [7:0] v);
    thresh_wr = 1'b1; thresh_wdata = v;
    tick();
    thresh_wr = 1'b0;
  endtask

  task automatic set_gie(input logic v);
    gie_wr = 1'b1; gie_wdata = v;
    tick();
    gie_wr = 1'b0;
  endtask

  task automatic put_req(input int src, input logic [7:0] lvl);
    req_pend = '0; req_lvl = '0;
    req_pend[src] = 1'b1;
    req_lvl[src*8 +: 8] = lvl;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(!trap_valid && !gie && cur_lvl == 0 && thresh == 0 && prev_lvl == 0 &&
        !prev_gie && epc == 0 && !resume_valid, "R1", "reset state",
        {trap_valid, gie, cur_lvl, thresh}, 64'h0);

    // table walk
    for (int k = 0; k < 7; k++) begin
      do_reset();
      req_pend = VEC[k].pend;
      req_lvl  = VEC[k].lvl;
      set_thresh(VEC[k].thr);
      set_gie(1'b1);
      tick();
      chk(trap_valid == VEC[k].ev, "R4/R5", $sformatf("vector %0d valid", k),
          trap_valid, VEC[k].ev);
      if (VEC[k].ev)
        chk(trap_id == VEC[k].eid && trap_lvl == VEC[k].elvl, "R5",
            $sformatf("vector %0d winner", k), {trap_id, trap_lvl}, {VEC[k].eid, VEC[k].elvl});
    end

    // R2 enable gates the offer
    do_reset();
    put_req(3, 8'd200);
    tick(); tick(); tick();
    chk(!trap_valid, "R2", "offer with enable clear", trap_valid, 0);
    set_gie(1'b1);
    chk(!trap_valid, "R6", "no offer in the edge of the enable write", trap_valid, 0);
    tick();
    chk(trap_valid && trap_id == 3 && trap_lvl == 200, "R2", "offer after enable",
        {trap_valid, trap_id, trap_lvl}, {1'b1, 3'd3, 8'd200});

    // R6 hold until ack
    put_req(4, 8'd250);
    tick(); tick();
    chk(trap_valid && trap_id == 3 && trap_lvl == 200, "R6", "offer held",
        {trap_valid, trap_id, trap_lvl}, {1'b1, 3'd3, 8'd200});

    // R7 entry
    do_reset();
    put_req(0, 8'd5);
    set_gie(1'b1);
    tick();
    core_pc = 32'h100; trap_ack = 1'b1;
    tick();
    trap_ack = 1'b0; req_pend = '0;
    chk(!trap_valid && !gie && cur_lvl == 5 && prev_lvl == 0 && prev_gie && epc == 32'h100,
        "R7", "trap entry", {trap_valid, gie, cur_lvl, prev_lvl, prev_gie, epc},
        {1'b0, 1'b0, 8'd5, 8'd0, 1'b1, 32'h100});

    // R8 nesting
    set_gie(1'b1);
    put_req(1, 8'd5);
    tick(); tick();
    chk(!trap_valid, "R8", "equal level does not pre-empt", trap_valid, 0);
    put_req(1, 8'd6);
    tick();
    chk(trap_valid && trap_id == 1 && trap_lvl == 6, "R8", "higher level offered",
        {trap_valid, trap_id, trap_lvl}, {1'b1, 3'd1, 8'd6});
    core_pc = 32'h200; trap_ack = 1'b1;
    tick();
    trap_ack = 1'b0; req_pend = '0;
    chk(epc == 32'h200 && cur_lvl == 6 && prev_lvl == 5 && prev_gie, "R8", "nested entry",
        {epc, cur_lvl, prev_lvl, prev_gie}, {32'h200, 8'd6, 8'd5, 1'b1});

    // R9 return
    mret = 1'b1;
    tick();
    mret = 1'b0;
    chk(resume_valid && resume_pc == 32'h200 && cur_lvl == 5 && gie, "R9", "return",
        {resume_valid, resume_pc, cur_lvl, gie}, {1'b1, 32'h200, 8'd5, 1'b1});
    tick();
    chk(!resume_valid, "R9", "resume is one cycle", resume_valid, 0);

    // R10 threshold write
    set_thresh(8'h33);
    chk(thresh == 8'h33, "R10", "threshold write", thresh, 8'h33);

    // R11 ack against enable write, return against enable write
    do_reset();
    put_req(2, 8'd9);
    set_gie(1'b1);
    tick();
    trap_ack = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b1;
    tick();
    trap_ack = 1'b0; gie_wr = 1'b0;
    chk(!gie && cur_lvl == 9, "R11", "entry beats enable write", {gie, cur_lvl}, {1'b0, 8'd9});
    mret = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b0;
    tick();
    mret = 1'b0; gie_wr = 1'b0;
    chk(gie && cur_lvl == 0, "R11", "return beats enable write", {gie, cur_lvl}, {1'b1, 8'd0});

    // R12 ack against return
    do_reset();
    put_req(2, 8'd9);
    set_gie(1'b1);
    tick();
    trap_ack = 1'b1; mret = 1'b1;
    tick();
    trap_ack = 1'b0; mret = 1'b0;
    chk(!resume_valid && cur_lvl == 9 && !gie, "R12", "entry beats return",
        {resume_valid, cur_lvl, gie}, {1'b0, 8'd9, 1'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule